// File: doc/BRIEF.md
# Sleep Interval Timer and Watchdog with Reset-Cause Register

The block divides a slow oscillator tick into a repeating sleep interval. Software picks one of four interval lengths and gets a one-cycle interrupt at the end of each interval. A watchdog counts these interval ends rather than system clock cycles. If software does not clear the watchdog before the third interval end, the block asks for a system reset.

The block also keeps a one-byte status and control register. Two flags in it record why the last reset happened: power-on or watchdog. Software can clear these flags but never set them. The same register lets software request CPU sleep or CPU halt, and it shows the global interrupt enable input in its top bit. The watchdog stays idle while the power-on flag is set. It arms when software clears that flag and stays armed until the next power-on reset.

The slow clock arrives as a single-cycle enable in the system clock domain. Register reads are combinational from the address; writes take effect at the clock edge on which the write strobe is high.

Top module: `slptmr_wdog`

## Requirements
- R1: After power-on reset the status byte reads 0x10 with the interrupt-enable input low (bit 4 power-on flag set, all other stored bits 0). All four outputs are low.
- R2: A write to the status byte may clear bit 5 (watchdog flag) or bit 4 (power-on flag) by writing 0 there. Writing 1 leaves the flag unchanged and never sets it.
- R3: The watchdog cannot fire while bit 4 is set. Clearing bit 4 arms it. Writing 1 to bit 4 afterwards does not disarm it. Only a power-on reset disarms it.
- R4: The sleep interval is 2^(BASE_LOG+3*sel) slow ticks, where sel is the 2-bit interval select (0 shortest, 3 longest). `slp_irq` is high for one system cycle, the cycle after the edge that takes the tick ending the interval.
- R5: When armed, the watchdog counts interval ends. On the third interval end since the last watchdog clear, it drives `wdog_rst` high for exactly one cycle, in the same cycle as that interval's `slp_irq`.
- R6: Any write to the watchdog-clear address zeroes the watchdog count. If the written byte is 0x38, the same write also zeroes the sleep interval counter.
- R7: Bit 3 of the status byte drives `cpu_sleep`. A pending interrupt clears it at the next edge, and it also wins over a write of 1 made in the same cycle.
- R8: Bit 0 drives `cpu_halt`. It can be set by writing 1. Writing 0 does not clear it. Only a watchdog, external or power-on reset clears it.
- R9: Bit 7 of the status byte reads the `gie_in` input. Bits 6, 2 and 1 always read 0. Reading any address other than the status address returns 0.
- R10: An external reset clears the sleep and halt bits and both counters. It keeps both reset-cause flags.
- R11: A watchdog reset sets bit 5 and clears the sleep and halt bits and both counters. The next timeout therefore takes three full intervals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| ext_rst_n | input | 1 | External reset, synchronous, active low |
| slow_tick | input | 1 | Single-cycle enable from the slow oscillator |
| ivl_sel | input | SEL_W | Sleep interval select |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| gie_in | input | 1 | Global interrupt enable, mirrored in bit 7 |
| irq_pending | input | 1 | Any interrupt pending, wakes from sleep |
| slp_irq | output | 1 | Sleep interval interrupt pulse |
| wdog_rst | output | 1 | Watchdog reset request pulse |
| cpu_sleep | output | 1 | CPU sleep request |
| cpu_halt | output | 1 | CPU halt request |

## Verification
A write, a reset or a pending interrupt changes the status byte and the sleep/halt outputs at the edge where it is sampled. The bench drives its inputs at a falling edge and reads the result at the next falling edge. `slp_irq` and `wdog_rst` are registered one edge after the terminal tick. For that reason the bench counts ticks one at a time, samples after every tick, and compares the count at which a pulse first appears with 2^(BASE_LOG+3*sel), or with a multiple of it shortened by any partial interval left over. Register contents are read combinationally half a cycle after the write edge.

// File: rtl/slpwd_pkg.sv
// Shared constants and types for the sleep timer / watchdog block.
// Assumes an 8-bit status byte whose bit positions are visible to software.
package slpwd_pkg;
    localparam int BIT_GIE   = 7;
    localparam int BIT_WDRS  = 5;
    localparam int BIT_PORS  = 4;
    localparam int BIT_SLEEP = 3;
    localparam int BIT_HALT  = 0;
    localparam logic [7:0] KICK_FULL = 8'h38;

    // Stored bits of the status/control byte.
    typedef struct packed {
        logic wdrs;
        logic pors;
        logic sleep;
        logic halt;
    } ctl_bits_t;
endpackage

// File: rtl/slpwd_sleep_timer.sv
// Sleep interval counter. Counts slow ticks up to a terminal count chosen
// by sel (2^(BASE_LOG+STEP_LOG*sel)), then wraps and pulses irq one cycle later.
// Assumes tick is a single-cycle enable in the clk domain.
module slpwd_sleep_timer #(
    parameter int BASE_LOG = 6,
    parameter int STEP_LOG = 3,
    parameter int SEL_W    = 2
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             drop,
    input  logic             fire,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic             ovf,
    output logic             irq
);
    localparam int NSEL  = 1 << SEL_W;
    localparam int CNT_W = BASE_LOG + STEP_LOG * (NSEL - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_tab [NSEL];

    // Terminal value per select, computed from the parameters.
    for (genvar g = 0; g < NSEL; g++) begin : g_last
        localparam longint unsigned LASTV = (64'd1 << (BASE_LOG + STEP_LOG * g)) - 64'd1;
        assign last_tab[g] = CNT_W'(LASTV);
    end

    // Interval end: a tick arriving at or beyond the terminal value.
    always_comb begin
        ovf = tick && (cnt_q >= last_tab[sel]);
    end

    // Count ticks; wrap at interval end; clear on reset events or full kick.
    always_ff @(posedge clk) begin
        if (!por_n || drop || fire) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= ovf ? '0 : cnt_q + 1'b1;
        end
    end

    // Registered one-cycle interrupt for each interval end.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            irq <= 1'b0;
        end else begin
            irq <= ovf && !drop;
        end
    end
endmodule

// File: rtl/slpwd_wdog.sv
// Watchdog counter. Counts interval ends while armed and fires on reaching
// THRESH. Any kick zeroes it. Assumes ovf is the sleep timer's wrap strobe.
module slpwd_wdog #(
    parameter int THRESH = 3
) (
    input  logic clk,
    input  logic por_n,
    input  logic drop,
    input  logic kick,
    input  logic arm,
    input  logic ovf,
    output logic fire,
    output logic wd_rst
);
    localparam int W = $clog2(THRESH + 1);
    localparam logic [W-1:0] LAST_CNT = W'(THRESH - 1);

    logic [W-1:0] cnt_q;

    // Timeout: the interval end that brings the count to THRESH.
    always_comb begin
        fire = arm && ovf && !kick && !drop && (cnt_q == LAST_CNT);
    end

    // Count interval ends while armed; clear on kick, reset or timeout.
    always_ff @(posedge clk) begin
        if (!por_n || drop || kick || fire || !arm) begin
            cnt_q <= '0;
        end else if (ovf) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // One-cycle registered reset request.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            wd_rst <= 1'b0;
        end else begin
            wd_rst <= fire;
        end
    end
endmodule

// File: rtl/slpwd_status.sv
// Status/control byte: reset-cause flags (clear-only), sleep request
// (cleared by pending interrupt), halt request (sticky until reset).
// Assumes fire and drop never assert together.
module slpwd_status
    import slpwd_pkg::*;
(
    input  logic      clk,
    input  logic      por_n,
    input  logic      drop,
    input  logic      fire,
    input  logic      wr,
    input  ctl_bits_t wbits,
    input  logic      irq_pending,
    input  logic      gie,
    output ctl_bits_t ctl,
    output logic [7:0] stat_byte
);
    // Update stored bits by priority: power-on, watchdog, external, software.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            ctl <= '{wdrs: 1'b0, pors: 1'b1, sleep: 1'b0, halt: 1'b0};
        end else if (fire) begin
            ctl.wdrs  <= 1'b1;
            ctl.sleep <= 1'b0;
            ctl.halt  <= 1'b0;
        end else if (drop) begin
            ctl.sleep <= 1'b0;
            ctl.halt  <= 1'b0;
        end else begin
            if (wr) begin
                ctl.wdrs  <= ctl.wdrs & wbits.wdrs;
                ctl.pors  <= ctl.pors & wbits.pors;
                ctl.sleep <= wbits.sleep && !irq_pending;
                ctl.halt  <= ctl.halt | wbits.halt;
            end else if (irq_pending) begin
                ctl.sleep <= 1'b0;
            end
        end
    end

    // Assemble the readable byte; reserved positions stay zero.
    always_comb begin
        stat_byte            = '0;
        stat_byte[BIT_GIE]   = gie;
        stat_byte[BIT_WDRS]  = ctl.wdrs;
        stat_byte[BIT_PORS]  = ctl.pors;
        stat_byte[BIT_SLEEP] = ctl.sleep;
        stat_byte[BIT_HALT]  = ctl.halt;
    end
endmodule

// File: rtl/slptmr_wdog.sv
// Top: sleep interval timer, watchdog and status/control byte on a simple
// register bus. Assumes synchronous active-low resets and a slow-tick enable.
module slptmr_wdog
    import slpwd_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'hFF,
    parameter logic [ADDR_W-1:0] KICK_ADDR = 8'hE3,
    parameter int              BASE_LOG  = 6,
    parameter int              STEP_LOG  = 3,
    parameter int              SEL_W     = 2,
    parameter int              THRESH    = 3
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              ext_rst_n,
    input  logic              slow_tick,
    input  logic [SEL_W-1:0]  ivl_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              gie_in,
    input  logic              irq_pending,
    output logic              slp_irq,
    output logic              wdog_rst,
    output logic              cpu_sleep,
    output logic              cpu_halt
);
    logic      stat_wr, kick, kick_full, drop, ovf, fire;
    logic      flag_pors, flag_wdrs;
    ctl_bits_t wbits, ctl;
    logic [7:0] stat_byte;

    // Decode bus writes and the external reset strobe.
    always_comb begin
        drop       = !ext_rst_n;
        stat_wr    = bus_wr && (bus_addr == STAT_ADDR) && !drop;
        kick       = bus_wr && (bus_addr == KICK_ADDR) && !drop;
        kick_full  = kick && (bus_wdata == KICK_FULL);
        wbits.wdrs  = bus_wdata[BIT_WDRS];
        wbits.pors  = bus_wdata[BIT_PORS];
        wbits.sleep = bus_wdata[BIT_SLEEP];
        wbits.halt  = bus_wdata[BIT_HALT];
    end

    slpwd_sleep_timer #(
        .BASE_LOG(BASE_LOG),
        .STEP_LOG(STEP_LOG),
        .SEL_W   (SEL_W)
    ) u_timer (
        .clk  (clk),
        .por_n(por_n),
        .drop (drop || kick_full),
        .fire (fire),
        .tick (slow_tick),
        .sel  (ivl_sel),
        .ovf  (ovf),
        .irq  (slp_irq)
    );

    slpwd_wdog #(
        .THRESH(THRESH)
    ) u_wdog (
        .clk   (clk),
        .por_n (por_n),
        .drop  (drop),
        .kick  (kick),
        .arm   (!ctl.pors),
        .ovf   (ovf),
        .fire  (fire),
        .wd_rst(wdog_rst)
    );

    slpwd_status u_stat (
        .clk        (clk),
        .por_n      (por_n),
        .drop       (drop),
        .fire       (fire),
        .wr         (stat_wr),
        .wbits      (wbits),
        .irq_pending(irq_pending),
        .gie        (gie_in),
        .ctl        (ctl),
        .stat_byte  (stat_byte)
    );

    // Drive request outputs, flags for checking, and read data.
    always_comb begin
        cpu_sleep = ctl.sleep;
        cpu_halt  = ctl.halt;
        flag_pors = ctl.pors;
        flag_wdrs = ctl.wdrs;
        bus_rdata = (bus_addr == STAT_ADDR) ? stat_byte : 8'h00;
    end
endmodule

// Property checker for slptmr_wdog, attached by bind below.
module slptmr_wdog_chk #(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'hFF
) (
    input logic              clk,
    input logic              por_n,
    input logic              ext_rst_n,
    input logic              irq_pending,
    input logic              gie_in,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_rdata,
    input logic              slp_irq,
    input logic              wdog_rst,
    input logic              cpu_sleep,
    input logic              cpu_halt,
    input logic              flag_pors,
    input logic              flag_wdrs
);
    p_por_load_r1: assert property (@(posedge clk) disable iff (!por_n)
        $past(!por_n) |-> (flag_pors && !flag_wdrs && !cpu_sleep && !cpu_halt && !wdog_rst && !slp_irq));

    p_pors_noset_r2: assert property (@(posedge clk) disable iff (!por_n)
        !flag_pors |=> !flag_pors);

    p_wdrs_noset_r2: assert property (@(posedge clk) disable iff (!por_n)
        $rose(flag_wdrs) |-> wdog_rst);

    p_wd_idle_r3: assert property (@(posedge clk) disable iff (!por_n)
        flag_pors |=> !wdog_rst);

    p_irq_pulse_r4: assert property (@(posedge clk) disable iff (!por_n)
        slp_irq |=> !slp_irq);

    p_wd_pulse_r5: assert property (@(posedge clk) disable iff (!por_n)
        wdog_rst |=> !wdog_rst);

    p_wd_on_ivl_r5: assert property (@(posedge clk) disable iff (!por_n)
        wdog_rst |-> slp_irq);

    p_wake_r7: assert property (@(posedge clk) disable iff (!por_n)
        irq_pending |=> !cpu_sleep);

    p_halt_hold_r8: assert property (@(posedge clk) disable iff (!por_n)
        (cpu_halt && ext_rst_n) |=> (cpu_halt || wdog_rst));

    p_reserved_r9: assert property (@(posedge clk) disable iff (!por_n)
        (bus_addr == STAT_ADDR) |-> (bus_rdata[6] == 1'b0 && bus_rdata[2:1] == 2'b00 && bus_rdata[7] == gie_in));

    p_ext_clr_r10: assert property (@(posedge clk) disable iff (!por_n)
        !ext_rst_n |=> (!cpu_sleep && !cpu_halt));

    p_wd_flag_r11: assert property (@(posedge clk) disable iff (!por_n)
        wdog_rst |-> (flag_wdrs && !cpu_halt && !cpu_sleep));
endmodule

bind slptmr_wdog slptmr_wdog_chk #(
    .ADDR_W   (ADDR_W),
    .STAT_ADDR(STAT_ADDR)
) u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .ext_rst_n  (ext_rst_n),
    .irq_pending(irq_pending),
    .gie_in     (gie_in),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .slp_irq    (slp_irq),
    .wdog_rst   (wdog_rst),
    .cpu_sleep  (cpu_sleep),
    .cpu_halt   (cpu_halt),
    .flag_pors  (flag_pors),
    .flag_wdrs  (flag_wdrs)
);

// File: tb/slptmr_wdog_tb.sv
// Bench for slptmr_wdog with BASE_LOG=2 (intervals 4, 32, 256, 2048 ticks).
module slptmr_wdog_tb;
    localparam int PER = 10;
    localparam int BL  = 2;
    localparam logic [7:0] SA = 8'hFF;
    localparam logic [7:0] KA = 8'hE3;

    logic clk = 1'b0, por_n = 1'b0, ext_rst_n = 1'b1, slow_tick = 1'b0;
    logic bus_wr = 1'b0, gie_in = 1'b0, irq_pending = 1'b0;
    logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
    logic [1:0] ivl_sel = 2'd0;
    logic [7:0] bus_rdata;
    logic slp_irq, wdog_rst, cpu_sleep, cpu_halt;

    int checks = 0, errors = 0, wd_seen = 0;
    bit done = 1'b0;

    slptmr_wdog #(.BASE_LOG(BL), .STAT_ADDR(SA), .KICK_ADDR(KA)) u_dut (
        .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .slow_tick(slow_tick),
        .ivl_sel(ivl_sel), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .gie_in(gie_in), .irq_pending(irq_pending),
        .slp_irq(slp_irq), .wdog_rst(wdog_rst), .cpu_sleep(cpu_sleep), .cpu_halt(cpu_halt)
    );

    always #(PER/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic one_tick();
        slow_tick = 1'b1;
        @(negedge clk);
        slow_tick = 1'b0;
        if (wdog_rst) wd_seen++;
    endtask

    // Tick until slp_irq, with 'gap' idle cycles between ticks.
    task automatic run_irq(input int gap, output int n);
        n = 0;
        do begin
            one_tick(); n++;
            if (!slp_irq) for (int i = 0; i < gap; i++) idle();
        end while (!slp_irq && n < 5000);
    endtask

    task automatic run_wd(output int n);
        n = 0;
        do begin one_tick(); n++; end while (!wdog_rst && n < 20000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog timeout actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int n, irqs;
        repeat (3) idle();
        por_n = 1'b1;
        // R1 reset state
        rd(SA, v); chk("R1 status", v, 8'h10);
        chk("R1 outputs", {slp_irq, wdog_rst, cpu_sleep, cpu_halt}, 0);
        // R9 mirror and reserved
        gie_in = 1'b1; rd(SA, v); chk("R9 gie mirror", v, 8'h90);
        gie_in = 1'b0;
        rd(8'h00, v); chk("R9 other addr", v, 0);
        rd(KA, v);    chk("R9 kick addr reads 0", v, 0);
        // R2 flags not settable, reserved stay 0
        wr(SA, 8'hF6); rd(SA, v); chk("R2/R9 write ones", v, 8'h10);
        // R4 all interval selects, two intervals each
        for (int s = 0; s < 4; s++) begin
            ivl_sel = 2'(s);
            wr(KA, 8'h38);
            run_irq(0, n); chk("R4 first interval", n, 1 << (BL + 3*s));
            idle(); chk("R4 pulse width", slp_irq, 0);
            run_irq(0, n); chk("R4 second interval", n, 1 << (BL + 3*s));
        end
        ivl_sel = 2'd0;
        run_irq(2, n); chk("R4 sparse ticks", n, 4);
        chk("R3 no timeout while flag set", wd_seen, 0);
        // R6 kick variants
        wr(KA, 8'h38); one_tick(); one_tick();
        wr(KA, 8'h38); run_irq(0, n); chk("R6 full kick clears timer", n, 4);
        one_tick(); one_tick();
        wr(KA, 8'h00); run_irq(0, n); chk("R6 plain kick keeps timer", n, 2);
        // R7 sleep and wake
        wr(SA, 8'h18); chk("R7 sleep set", cpu_sleep, 1);
        irq_pending = 1'b1; idle(); chk("R7 wake", cpu_sleep, 0);
        wr(SA, 8'h18); chk("R7 wake beats write", cpu_sleep, 0);
        irq_pending = 1'b0;
        // R8 halt sticky
        wr(SA, 8'h11); chk("R8 halt set", cpu_halt, 1);
        wr(SA, 8'h10); chk("R8 halt not cleared by write", cpu_halt, 1);
        // R10 external reset
        one_tick(); one_tick();
        ext_rst_n = 1'b0; idle(); ext_rst_n = 1'b1;
        chk("R10 halt cleared", cpu_halt, 0);
        rd(SA, v); chk("R10 flags kept", v, 8'h10);
        run_irq(0, n); chk("R10 timer cleared", n, 4);
        // R3/R5/R11 arm and timeout
        wr(SA, 8'h00); rd(SA, v); chk("R2 clear pors", v, 8'h00);
        wr(KA, 8'h38);
        wr(SA, 8'h09);
        run_wd(n); chk("R5 timeout three intervals", n, 12);
        chk("R5 timeout with irq", slp_irq, 1);
        rd(SA, v); chk("R11 status after timeout", v, 8'h20);
        chk("R11 sleep/halt cleared", {cpu_sleep, cpu_halt}, 0);
        idle(); chk("R5 reset pulse width", wdog_rst, 0);
        run_wd(n); chk("R11 counters cleared", n, 12);
        // R5 partial interval shortens timeout
        for (int i = 0; i < 6; i++) one_tick();
        wr(KA, 8'h00);
        run_wd(n); chk("R5 short timeout", n, 10);
        // R3 cannot disarm
        wr(SA, 8'h30); rd(SA, v); chk("R3 pors not settable", v, 8'h20);
        wr(KA, 8'h38);
        run_wd(n); chk("R3 still armed", n, 12);
        wr(SA, 8'h00); rd(SA, v); chk("R2 clear wdrs", v, 8'h00);
        // R3 power-on disarms
        por_n = 1'b0; idle(); por_n = 1'b1;
        rd(SA, v); chk("R1 status after second por", v, 8'h10);
        wd_seen = 0; irqs = 0;
        for (int i = 0; i < 40; i++) begin one_tick(); if (slp_irq) irqs++; end
        chk("R3 disarmed by por", wd_seen, 0);
        chk("R4 interrupt count", irqs, 10);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule